// File: doc/BRIEF.md
# Host memory-access slave port

This block gives an external host direct access to a signal processor's internal program store (24-bit words) and data store (16-bit words) over one 16-bit multiplexed address/data bus. The host first performs an address-latch write (a write with the latch-enable input high). Bit 15 of that value decides its meaning. When bit 15 is 0, the value sets a 14-bit word address and a memory-type bit. When bit 15 is 1, the value loads an 8-bit overlay page register. Plain reads and writes then move words to and from the chosen memory. The address steps on its own after each complete word, so a block of words needs only one latch cycle.

Program words are wider than the bus, so each one takes two accesses: the upper 16 bits first, then the low byte right-aligned. A half-word toggle tracks which half comes next, and the address steps only after the second half. After every accepted access the port raises a busy acknowledge for a fixed number of clocks; the host waits for it to fall before its next access. In boot mode, a completed program write to address 0 starts the processor core through a sticky start output. The two internal memories are plain synchronous arrays with one cycle of read latency, modelled outside the block.

Top module: `hostmem_port`

## Requirements
- R1: A write with `host_ale` high and `host_din[15]`=0 loads the word address from `host_din[13:0]` and the memory type from `host_din[14]` (0 = program store, 1 = data store). Later accesses go to that location.
- R2: A write with `host_ale` high and `host_din[15]`=1 loads `ovl_page` from `host_din[7:0]` and leaves the word address and memory type unchanged.
- R3: When a write of the R2 kind has any bit of `host_din[14:8]` nonzero, `ovl_page` is still loaded and `ovl_err` goes high. `ovl_err` stays high until reset.
- R4: Each data-store read or write moves one 16-bit word and then adds one to the address. The address wraps from 0x3FFF to 0x0000.
- R5: A program-store write takes two accesses. The first carries bits 23:8 of the word. The second carries bits 7:0 in `host_din[7:0]`; `host_din[15:8]` of that access is ignored. The 24-bit word is written once, on the second access, and the address then steps by one.
- R6: A program-store read takes two accesses. The first returns bits 23:8 of the word. The second returns {8'h00, bits 7:0}. The address steps by one after the second access.
- R7: Any address-latch write resets the half-word toggle, so the next program access is treated as an upper half.
- R8: After each accepted access, `host_busy` is high for exactly BUSY_CYC clocks and then falls. A strobe that arrives while `host_busy` is high, or while `host_sel` is low, is ignored.
- R9: With `boot_mode` high, a completed program-store write to address 0x0000 sets `core_start` one clock later, and `core_start` then stays high. With `boot_mode` low, the same write leaves `core_start` low.
- R10: A read ignores `host_ale` and always returns memory data. The latched address cannot be read back.
- R11: After reset, `host_busy`, `core_start`, `ovl_err`, `ovl_page` and `host_dout` are 0, and the address is program address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_mode | input | 1 | Boot mode: a program write to address 0 starts the core |
| host_sel | input | 1 | Host select, active high |
| host_ale | input | 1 | Address latch enable, used on writes |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_din | input | 16 | Bus value from the host |
| host_dout | output | 16 | Read data to the host |
| host_busy | output | 1 | Acknowledge: high while an access is in progress |
| core_start | output | 1 | Sticky start signal raised when boot ends |
| ovl_page | output | 8 | Overlay page register |
| ovl_err | output | 1 | Sticky flag for an overlay write with nonzero guard bits |
| pm_addr | output | 14 | Program store address |
| pm_we | output | 1 | Program store write enable |
| pm_re | output | 1 | Program store read enable |
| pm_wdata | output | 24 | Program store write data |
| pm_rdata | input | 24 | Program store read data, one cycle after `pm_re` |
| dm_addr | output | 14 | Data store address |
| dm_we | output | 1 | Data store write enable |
| dm_re | output | 1 | Data store read enable |
| dm_wdata | output | 16 | Data store write data |
| dm_rdata | input | 16 | Data store read data, one cycle after `dm_re` |

## Verification
Random bursts of one to six words go to either memory from a random base address, and each burst is read back after a fresh latch. This separates correct packing and address stepping from a shifted, swapped or skipped half. Directed patterns cover the cases random bursts rarely reach:
- address wrap at the top of the space;
- an overlay write placed between two data writes, which shows the address was left alone;
- a latch issued after a lone upper half, which shows the toggle resets;
- strobes issued while busy or without select, which show they are ignored;
- a read with latch enable high, which tells a data read from an address read-back.

Program writes to address 0 are issued with boot mode both low and high, which shows the start output depends on the mode.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
   typedef enum logic {MEM_PM = 1'b0, MEM_DM = 1'b1} mem_sel_e;
   typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;
   typedef struct packed {
      logic latch;
      logic wr;
      logic rd;
   } acc_s;
endpackage

// File: rtl/hmp_addr_unit.sv
module hmp_addr_unit
   import hmp_pkg::*;
#(
   parameter int AW     = 14,
   parameter int BUS_W  = 16,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic              step,
   input  logic [BUS_W-1:0]  din,
   output logic [AW-1:0]     addr,
   output mem_sel_e          mtype,
   output logic [PAGE_W-1:0] page,
   output logic              err
);
   localparam int SEL_BIT  = BUS_W - 1;
   localparam int TYPE_BIT = BUS_W - 2;

   if (AW > BUS_W - 2) begin : g_bad_aw
      $error("hmp_addr_unit: address does not fit below the type bit");
   end
   if (PAGE_W > BUS_W - 1) begin : g_bad_page
      $error("hmp_addr_unit: page wider than the bus allows");
   end

   logic guard_nz;
   if (PAGE_W < BUS_W - 1) begin : g_guard
      assign guard_nz = |din[TYPE_BIT:PAGE_W];
   end else begin : g_no_guard
      assign guard_nz = 1'b0;
   end

   logic to_page;
   assign to_page = din[SEL_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         mtype <= MEM_PM;
         page  <= '0;
         err   <= 1'b0;
      end else if (latch) begin
         if (to_page) begin
            page <= din[PAGE_W-1:0];
            if (guard_nz) err <= 1'b1;
         end else begin
            addr  <= din[AW-1:0];
            mtype <= mem_sel_e'(din[TYPE_BIT]);
         end
      end else if (step) begin
         addr <= addr + AW'(1);
      end
   end
endmodule

// File: rtl/hmp_half_tracker.sv
module hmp_half_tracker
   import hmp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  latch,
   input  logic  pm_access,
   output half_e half
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         half <= HALF_HI;
      else if (latch)     half <= HALF_HI;
      else if (pm_access) half <= (half == HALF_HI) ? HALF_LO : HALF_HI;
   end
endmodule

// File: rtl/hmp_ack_timer.sv
module hmp_ack_timer #(
   parameter int BUSY_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC < 2) begin : g_bad_busy
      $error("hmp_ack_timer: read data needs at least two busy cycles");
   end

   logic [CW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= CW'(BUSY_CYC);
      else if (cnt != '0)      cnt <= cnt - CW'(1);
   end
   assign busy = (cnt != '0);
endmodule

// File: rtl/hmp_data_path.sv
module hmp_data_path
   import hmp_pkg::*;
#(
   parameter int BUS_W = 16,
   parameter int PW    = 24,
   parameter int DW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_wr,
   input  logic             do_rd,
   input  mem_sel_e         mtype,
   input  half_e            half,
   input  logic [BUS_W-1:0] din,
   input  logic [PW-1:0]    pm_rdata,
   input  logic [DW-1:0]    dm_rdata,
   output logic             pm_we,
   output logic             pm_re,
   output logic [PW-1:0]    pm_wdata,
   output logic             dm_we,
   output logic             dm_re,
   output logic [DW-1:0]    dm_wdata,
   output logic [BUS_W-1:0] dout,
   output logic             pm_access,
   output logic             step
);
   localparam int LOW_W = PW - BUS_W;

   if (DW != BUS_W) begin : g_bad_dw
      $error("hmp_data_path: data word must match the bus width");
   end
   if (PW <= BUS_W || PW > 2 * BUS_W) begin : g_bad_pw
      $error("hmp_data_path: program word must take exactly two accesses");
   end

   logic              is_pm;
   logic              lo_half;
   logic [BUS_W-1:0]  hi_hold;
   logic [LOW_W-1:0]  lo_buf;
   logic              pend_pm;
   logic              pend_dm;

   assign is_pm     = (mtype == MEM_PM);
   assign lo_half   = (half == HALF_LO);
   assign pm_we     = do_wr & is_pm & lo_half;
   assign pm_re     = do_rd & is_pm & ~lo_half;
   assign dm_we     = do_wr & ~is_pm;
   assign dm_re     = do_rd & ~is_pm;
   assign pm_wdata  = {hi_hold, din[LOW_W-1:0]};
   assign dm_wdata  = din;
   assign pm_access = (do_wr | do_rd) & is_pm;
   assign step      = (do_wr | do_rd) & (~is_pm | lo_half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_hold <= '0;
         lo_buf  <= '0;
         pend_pm <= 1'b0;
         pend_dm <= 1'b0;
         dout    <= '0;
      end else begin
         pend_pm <= pm_re;
         pend_dm <= dm_re;
         if (do_wr && is_pm && !lo_half) hi_hold <= din;
         if (pend_pm) begin
            dout   <= pm_rdata[PW-1:LOW_W];
            lo_buf <= pm_rdata[LOW_W-1:0];
         end else if (pend_dm) begin
            dout <= dm_rdata;
         end else if (do_rd && is_pm && lo_half) begin
            dout <= {{(BUS_W-LOW_W){1'b0}}, lo_buf};
         end
      end
   end
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
   import hmp_pkg::*;
#(
   parameter int AW       = 14,
   parameter int BUS_W    = 16,
   parameter int PW       = 24,
   parameter int PAGE_W   = 8,
   parameter int BUSY_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_mode,
   input  logic              host_sel,
   input  logic              host_ale,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [BUS_W-1:0]  host_din,
   output logic [BUS_W-1:0]  host_dout,
   output logic              host_busy,
   output logic              core_start,
   output logic [PAGE_W-1:0] ovl_page,
   output logic              ovl_err,
   output logic [AW-1:0]     pm_addr,
   output logic              pm_we,
   output logic              pm_re,
   output logic [PW-1:0]     pm_wdata,
   input  logic [PW-1:0]     pm_rdata,
   output logic [AW-1:0]     dm_addr,
   output logic              dm_we,
   output logic              dm_re,
   output logic [BUS_W-1:0]  dm_wdata,
   input  logic [BUS_W-1:0]  dm_rdata
);
   acc_s           acc;
   logic [AW-1:0]  addr;
   mem_sel_e       mtype;
   half_e          half;
   logic           step;
   logic           pm_access;
   logic           go_wr;
   logic           go_rd;

   assign go_wr     = host_sel & host_wr & ~host_rd & ~host_busy;
   assign go_rd     = host_sel & host_rd & ~host_wr & ~host_busy;
   assign acc.latch = go_wr & host_ale;
   assign acc.wr    = go_wr & ~host_ale;
   assign acc.rd    = go_rd;

   hmp_ack_timer #(.BUSY_CYC(BUSY_CYC)) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc.latch | acc.wr | acc.rd),
      .busy  (host_busy)
   );

   hmp_addr_unit #(.AW(AW), .BUS_W(BUS_W), .PAGE_W(PAGE_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .latch (acc.latch),
      .step  (step),
      .din   (host_din),
      .addr  (addr),
      .mtype (mtype),
      .page  (ovl_page),
      .err   (ovl_err)
   );

   hmp_half_tracker u_half (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch     (acc.latch),
      .pm_access (pm_access),
      .half      (half)
   );

   hmp_data_path #(.BUS_W(BUS_W), .PW(PW), .DW(BUS_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_wr     (acc.wr),
      .do_rd     (acc.rd),
      .mtype     (mtype),
      .half      (half),
      .din       (host_din),
      .pm_rdata  (pm_rdata),
      .dm_rdata  (dm_rdata),
      .pm_we     (pm_we),
      .pm_re     (pm_re),
      .pm_wdata  (pm_wdata),
      .dm_we     (dm_we),
      .dm_re     (dm_re),
      .dm_wdata  (dm_wdata),
      .dout      (host_dout),
      .pm_access (pm_access),
      .step      (step)
   );

   assign pm_addr = addr;
   assign dm_addr = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   core_start <= 1'b0;
      else if (boot_mode && pm_we && addr == '0)    core_start <= 1'b1;
   end
endmodule

// File: rtl/hostmem_port_chk.sv
module hostmem_port_chk #(
   parameter int AW     = 14,
   parameter int PAGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_ale,
   input logic              host_rd,
   input logic              host_wr,
   input logic              host_busy,
   input logic              core_start,
   input logic [PAGE_W-1:0] ovl_page,
   input logic              ovl_err,
   input logic [AW-1:0]     pm_addr,
   input logic              pm_we,
   input logic              pm_re,
   input logic [AW-1:0]     dm_addr,
   input logic              dm_we,
   input logic              dm_re
);
   // R8: an accepted strobe makes the port busy on the next cycle
   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && (host_rd ^ host_wr) && !host_busy) |=> host_busy);

   // R8: no memory operation is issued while busy
   a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |-> !(pm_we || pm_re || dm_we || dm_re));

   // R5: at most one memory operation per cycle
   a_r5_one_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pm_we, pm_re, dm_we, dm_re}));

   // R4: a data-store write steps the address by one
   a_r4_dm_step: assert property (@(posedge clk) disable iff (!rst_n)
      dm_we |=> (dm_addr == $past(dm_addr) + AW'(1)));

   // R5: a completed program write steps the address by one
   a_r5_pm_step: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we |=> (pm_addr == $past(pm_addr) + AW'(1)));

   // R3: the overlay error flag is sticky
   a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_err |=> ovl_err);

   // R9: the start output is sticky
   a_r9_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> core_start);

   // R2: the overlay page changes only on an accepted latch write
   a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && host_wr && !host_rd && host_ale && !host_busy) |=> $stable(ovl_page));
endmodule

bind hostmem_port hostmem_port_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_ale   (host_ale),
   .host_rd    (host_rd),
   .host_wr    (host_wr),
   .host_busy  (host_busy),
   .core_start (core_start),
   .ovl_page   (ovl_page),
   .ovl_err    (ovl_err),
   .pm_addr    (pm_addr),
   .pm_we      (pm_we),
   .pm_re      (pm_re),
   .dm_addr    (dm_addr),
   .dm_we      (dm_we),
   .dm_re      (dm_re)
);

// File: tb/hostmem_port_bench.sv
module hostmem_port_bench;
   localparam int BUSY_CYC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_mode = 1'b0;
   logic        host_sel = 1'b0, host_ale = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_din = '0;
   logic [15:0] host_dout;
   logic        host_busy, core_start, ovl_err;
   logic [7:0]  ovl_page;
   logic [13:0] pm_addr, dm_addr;
   logic        pm_we, pm_re, dm_we, dm_re;
   logic [23:0] pm_wdata, pm_rdata;
   logic [15:0] dm_wdata, dm_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hostmem_port #(.BUSY_CYC(BUSY_CYC)) u_hostmem_port (
      .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
      .host_sel(host_sel), .host_ale(host_ale), .host_rd(host_rd), .host_wr(host_wr),
      .host_din(host_din), .host_dout(host_dout), .host_busy(host_busy),
      .core_start(core_start), .ovl_page(ovl_page), .ovl_err(ovl_err),
      .pm_addr(pm_addr), .pm_we(pm_we), .pm_re(pm_re), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
      .dm_addr(dm_addr), .dm_we(dm_we), .dm_re(dm_re), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata)
   );

   // memory models, 256 entries each, indexed by the low address byte
   logic [23:0] pm_mem [256];
   logic [15:0] dm_mem [256];
   logic [23:0] exp_pm [256];
   logic [15:0] exp_dm [256];

   initial begin
      for (int i = 0; i < 256; i++) begin
         pm_mem[i] = '0; dm_mem[i] = '0; exp_pm[i] = '0; exp_dm[i] = '0;
      end
      pm_rdata = '0;
      dm_rdata = '0;
   end

   always @(posedge clk) begin
      if (pm_we) pm_mem[pm_addr[7:0]] <= pm_wdata;
      if (pm_re) pm_rdata <= pm_mem[pm_addr[7:0]];
      if (dm_we) dm_mem[dm_addr[7:0]] <= dm_wdata;
      if (dm_re) dm_rdata <= dm_mem[dm_addr[7:0]];
   end

   function automatic logic [15:0] addr_word(input logic is_dm, input logic [13:0] a);
      return {1'b0, is_dm, a};
   endfunction
   function automatic logic [15:0] hi_part(input logic [23:0] w);
      return w[23:8];
   endfunction
   function automatic logic [15:0] lo_part(input logic [23:0] w);
      return {8'h00, w[7:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_op(input logic w, input logic a, input logic [15:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = w; host_rd = ~w; host_ale = a; host_din = d;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_ale = 1'b0;
      while (host_busy) @(negedge clk);
   endtask

   task automatic latch(input logic [15:0] v);
      bus_op(1'b1, 1'b1, v);
   endtask

   task automatic wr_pm(input logic [23:0] w);
      bus_op(1'b1, 1'b0, hi_part(w));
      bus_op(1'b1, 1'b0, {8'($urandom), w[7:0]});
   endtask

   task automatic rd_word(output logic [15:0] v);
      bus_op(1'b0, 1'b0, 16'h0);
      v = host_dout;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [23:0] w;
      int n;
      void'($urandom(32'h1D3A_5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk("R11 busy", host_busy, 0);
      chk("R11 start", core_start, 0);
      chk("R11 err", ovl_err, 0);
      chk("R11 page", ovl_page, 0);
      chk("R11 dout", host_dout, 0);
      chk("R11 addr", pm_addr, 0);

      // R8 busy length
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_ale = 1; host_din = addr_word(1, 14'h10);
      @(negedge clk);
      host_sel = 0; host_wr = 0; host_ale = 0;
      n = 0;
      while (host_busy) begin n++; @(negedge clk); end
      chk("R8 busy cycles", n, BUSY_CYC);

      // R8 strobe while busy ignored; R4 DM stepping
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_din = 16'hAAAA;
      @(negedge clk);
      host_din = 16'hBBBB;
      @(negedge clk);
      host_sel = 0; host_wr = 0;
      while (host_busy) @(negedge clk);
      bus_op(1, 0, 16'hCCCC);
      chk("R8 first write", dm_mem[8'h10], 16'hAAAA);
      chk("R8 busy strobe ignored", dm_mem[8'h11], 16'hCCCC);
      exp_dm[8'h10] = 16'hAAAA; exp_dm[8'h11] = 16'hCCCC;
      // R8 no select ignored
      @(negedge clk);
      host_wr = 1; host_din = 16'hDDDD;
      @(negedge clk);
      chk("R8 no-select busy", host_busy, 0);
      host_wr = 0;
      repeat (2) @(negedge clk);
      chk("R8 no-select write ignored", dm_mem[8'h12], 16'h0);

      // R1 and R4 wrap
      latch(addr_word(1, 14'h3FFF));
      bus_op(1, 0, 16'h1111);
      bus_op(1, 0, 16'h2222);
      chk("R4 wrap top", dm_mem[8'hFF], 16'h1111);
      chk("R4 wrap zero", dm_mem[8'h00], 16'h2222);
      exp_dm[8'hFF] = 16'h1111; exp_dm[8'h00] = 16'h2222;
      latch(addr_word(1, 14'h3FFF));
      rd_word(v); chk("R1 read top", v, 16'h1111);
      rd_word(v); chk("R4 read wrapped", v, 16'h2222);

      // R2 overlay leaves address alone
      latch(addr_word(1, 14'h30));
      bus_op(1, 0, 16'h3030);
      latch(16'h80A5);
      chk("R2 page", ovl_page, 8'hA5);
      chk("R2 no err", ovl_err, 0);
      bus_op(1, 0, 16'h3131);
      chk("R2 address kept", dm_mem[8'h31], 16'h3131);
      exp_dm[8'h30] = 16'h3030; exp_dm[8'h31] = 16'h3131;

      // R3 guard bits
      latch(16'h8155);
      chk("R3 page loaded", ovl_page, 8'h55);
      chk("R3 err set", ovl_err, 1);
      latch(16'h8011);
      chk("R3 page again", ovl_page, 8'h11);
      chk("R3 err sticky", ovl_err, 1);

      // R5 and R7: lone upper half, then relatch
      latch(addr_word(0, 14'h5));
      bus_op(1, 0, 16'hDEAD);
      latch(addr_word(0, 14'h6));
      wr_pm(24'hABCDEF);
      chk("R7 no write at 5", pm_mem[8'h05], 24'h0);
      chk("R7 toggle reset", pm_mem[8'h06], 24'hABCDEF);
      exp_pm[8'h06] = 24'hABCDEF;

      // R6 PM readback
      latch(addr_word(0, 14'h6));
      rd_word(v); chk("R6 upper", v, 16'hABCD);
      rd_word(v); chk("R6 lower", v, 16'h00EF);

      // R10 read with ale returns data
      latch(addr_word(1, 14'h30));
      bus_op(0, 1, 16'h0);
      chk("R10 read ignores ale", host_dout, 16'h3030);

      // R9 boot mode off
      latch(addr_word(0, 14'h0));
      wr_pm(24'h123456);
      exp_pm[8'h00] = 24'h123456;
      chk("R9 no start without boot", core_start, 0);

      // random bursts: R1 R4 R5 R6
      for (int it = 0; it < 40; it++) begin
         logic        is_dm;
         logic [13:0] base;
         int          len;
         is_dm = 1'($urandom);
         base  = 14'(8'h40 + ($urandom % 96));
         len   = 1 + ($urandom % 6);
         latch(addr_word(is_dm, base));
         for (int k = 0; k < len; k++) begin
            if (is_dm) begin
               v = 16'($urandom);
               bus_op(1, 0, v);
               exp_dm[8'(base + 14'(k))] = v;
            end else begin
               w = 24'($urandom);
               wr_pm(w);
               exp_pm[8'(base + 14'(k))] = w;
            end
         end
         latch(addr_word(is_dm, base));
         for (int k = 0; k < len; k++) begin
            if (is_dm) begin
               rd_word(v);
               chk("R4 random dm", v, exp_dm[8'(base + 14'(k))]);
            end else begin
               rd_word(v);
               chk("R6 random pm hi", v, hi_part(exp_pm[8'(base + 14'(k))]));
               rd_word(v);
               chk("R5 random pm lo", v, lo_part(exp_pm[8'(base + 14'(k))]));
            end
         end
      end

      // R9 boot mode on
      boot_mode = 1'b1;
      latch(addr_word(0, 14'h1));
      wr_pm(24'h000111);
      chk("R9 no start at addr 1", core_start, 0);
      latch(addr_word(0, 14'h0));
      wr_pm(24'h0A0B0C);
      chk("R9 start raised", core_start, 1);
      boot_mode = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 start sticky", core_start, 1);

      finish_run();
   end
endmodule